// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block moves the bits of an 8-, 16- or 32-bit operand left or right by a count from 0 to 31. It offers eight operations: logical and arithmetic shifts, plain rotates, and rotates that pass through the carry flag. Each request takes the operand, an operation code, a size code, a count and the incoming carry flag. One clock later the block presents the result, the new carry flag and, for shifts, zero and sign flags. The size is chosen per request, so one instance can serve byte, word and doubleword work in any order.

The carry flag always ends up holding the last bit that left the operand, however large the count. In the rotate-through-carry operations the carry acts as one extra bit above the operand, so the rotated value is one bit wider than the operand. The zero and sign flags are state that the block keeps. Shifts with a nonzero count rewrite them. Rotates, and any request whose count is zero after masking, leave them as they were.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation codes 0 and 1 (left shift, two names for one function) give the same result: the operand moves left by the count and zeros enter at bit 0. The result is zero above the selected size.
- R2: Operation code 2 (logical right shift) moves the operand right and zeros enter at the top bit of the selected size.
- R3: Operation code 3 (arithmetic right shift) moves the operand right and fills the vacated top bits with copies of the operand's sign bit, which is the top bit of the selected size.
- R4: For operation codes 0 to 3 the new carry is the last bit shifted out. When the count exceeds the size, that bit is 0 for codes 0 to 2 and the sign bit for code 3.
- R5: Operation codes 4 (rotate left) and 5 (rotate right) rotate the operand by the count modulo the size. The new carry is result bit 0 after a left rotate and the result's top bit after a right rotate, and this holds even when the count is a multiple of the size.
- R6: Operation codes 6 (rotate left through carry) and 7 (rotate right through carry) rotate the value {carry_in, operand}, which is size+1 bits wide, by the count modulo size+1. The new carry is the top bit of the rotated value and the result is the bits below it.
- R7: Only bits [4:0] of the count are used. The upper count bits have no effect.
- R8: A masked count of zero gives result = operand (truncated to the size) and carry_out = carry_in, and it leaves zero_out and sign_out unchanged.
- R9: A shift (codes 0 to 3) with a nonzero masked count sets zero_out when the result is 0 and copies the result's top bit into sign_out. Rotates (codes 4 to 7) leave both flags unchanged.
- R10: The outputs update one clock after a request with in_valid high. out_valid is high in exactly that cycle. Reset clears all outputs to 0.
- R11: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size code |
| count | input | 8 | Shift or rotate count; only bits [4:0] are used |
| carry_in | input | 1 | Incoming carry flag |
| operand | input | 32 | Value to shift or rotate |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 32 | Shifted or rotated value, zero above the size |
| carry_out | output | 1 | New carry flag |
| zero_out | output | 1 | Zero flag held from the last shift |
| sign_out | output | 1 | Sign flag held from the last shift |

## Verification
Two cases are of interest. In the first, a rotate through carry has a nonzero count that is an exact multiple of size+1. The wrap rule then gives an unchanged result and carry, while the flags are held because the operation is a rotate. The bench provokes this with an 8-bit rotate by 9 and checks that the operand and the incoming carry come back unchanged. In the second, a zero count and a held flag pair meet in one request: a shift first sets zero_out, then a zero-count request follows. The bench judges that the result is passed through, that carry_in is copied to carry_out, and that zero_out stays set.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int CNT_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic [7:0]  count,
  input  logic        carry_in,
  input  logic [31:0] operand,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        carry_out,
  output logic        zero_out,
  output logic        sign_out
);

  logic [5:0]  w;
  logic [5:0]  k;
  logic [4:0]  msb;
  logic [31:0] wmask;
  logic [31:0] x;
  logic [31:0] xs;

  always_comb begin
    case (size)
      2'd0:    w = 6'd8;
      2'd1:    w = 6'd16;
      default: w = 6'd32;
    endcase
  end

  assign k     = {{(6 - CNT_W){1'b0}}, count[CNT_W-1:0]};
  assign msb   = 5'(w - 6'd1);
  assign wmask = 32'((64'd1 << w) - 64'd1);
  assign x     = operand & wmask;
  assign xs    = x[msb] ? (x | ~wmask) : x;

  logic [63:0] shl_v;
  logic [32:0] shr_v;
  logic [32:0] sar_v;
  assign shl_v = {32'd0, x} << k;
  assign shr_v = {x, 1'b0} >> k;
  assign sar_v = 33'($signed({xs, 1'b0}) >>> k);

  logic [5:0]  rr;
  logic [63:0] rol_v;
  logic [63:0] ror_v;
  assign rr    = k & (w - 6'd1);
  assign rol_v = ({32'd0, x} << rr) | ({32'd0, x} >> (w - rr));
  assign ror_v = ({32'd0, x} >> rr) | ({32'd0, x} << (w - rr));

  logic [5:0]  rn;
  logic [6:0]  wi;
  logic [65:0] cv;
  logic [65:0] cmask;
  logic [65:0] rcl_v;
  logic [65:0] rcr_v;
  assign rn    = 6'(k % (w + 6'd1));
  assign wi    = {1'b0, w};
  assign cv    = {34'd0, x} | (66'(carry_in) << w);
  assign cmask = (66'd1 << (w + 6'd1)) - 66'd1;
  assign rcl_v = ((cv << rn) | (cv >> (w + 6'd1 - rn))) & cmask;
  assign rcr_v = ((cv >> rn) | (cv << (w + 6'd1 - rn))) & cmask;

  logic [31:0] nres;
  logic        ncf;

  always_comb begin
    case (op)
      3'd0, 3'd1: begin nres = shl_v[31:0] & wmask;  ncf = shl_v[w];       end
      3'd2:       begin nres = shr_v[32:1] & wmask;  ncf = shr_v[0];       end
      3'd3:       begin nres = sar_v[32:1] & wmask;  ncf = sar_v[0];       end
      3'd4:       begin nres = rol_v[31:0] & wmask;  ncf = rol_v[0];       end
      3'd5:       begin nres = ror_v[31:0] & wmask;  ncf = ror_v[msb];     end
      3'd6:       begin nres = rcl_v[31:0] & wmask;  ncf = rcl_v[wi];      end
      default:    begin nres = rcr_v[31:0] & wmask;  ncf = rcr_v[wi];      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      sign_out  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (k == 6'd0) begin
          result    <= x;
          carry_out <= carry_in;
        end else begin
          result    <= nres;
          carry_out <= ncf;
          if (!op[2]) begin
            zero_out <= (nres == 32'd0);
            sign_out <= nres[msb];
          end
        end
      end
    end
  end

  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && k == 6'd0 |=> result == $past(x) && carry_out == $past(carry_in)
      && $stable(zero_out) && $stable(sign_out)); // R8

  AST_ROT_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op[2] |=> $stable(zero_out) && $stable(sign_out)); // R9

  AST_SHIFT_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !op[2] && k != 6'd0 |=> zero_out == (result == 32'd0)); // R9

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10

  AST_SIZE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (result & ~$past(wmask)) == 32'd0); // R11

endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [7:0]  count = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out, zero_out, sign_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .count(count), .carry_in(carry_in), .operand(operand), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .zero_out(zero_out), .sign_out(sign_out)
  );

  // {op, size, count, carry_in, operand, expected result, expected carry}
  localparam logic [78:0] VEC [NV] = '{
    {3'd0, 2'd0, 8'd1,  1'b0, 32'h0000_0081, 32'h0000_0002, 1'b1}, // R1 R4
    {3'd1, 2'd0, 8'd1,  1'b0, 32'h0000_0081, 32'h0000_0002, 1'b1}, // R1
    {3'd0, 2'd1, 8'd4,  1'b0, 32'h0000_1234, 32'h0000_2340, 1'b1}, // R1 R4
    {3'd0, 2'd0, 8'd8,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R4
    {3'd0, 2'd0, 8'd9,  1'b1, 32'h0000_00FF, 32'h0000_0000, 1'b0}, // R4
    {3'd2, 2'd0, 8'd3,  1'b0, 32'h0000_0085, 32'h0000_0010, 1'b1}, // R2
    {3'd2, 2'd2, 8'd31, 1'b1, 32'h8000_0000, 32'h0000_0001, 1'b0}, // R2
    {3'd3, 2'd0, 8'd2,  1'b1, 32'h0000_0084, 32'h0000_00E1, 1'b0}, // R3
    {3'd3, 2'd0, 8'd20, 1'b0, 32'h0000_0080, 32'h0000_00FF, 1'b1}, // R3 R4
    {3'd3, 2'd1, 8'd1,  1'b0, 32'h0000_4001, 32'h0000_2000, 1'b1}, // R3
    {3'd4, 2'd0, 8'd1,  1'b0, 32'h0000_0081, 32'h0000_0003, 1'b1}, // R5
    {3'd5, 2'd1, 8'd4,  1'b1, 32'h0000_1234, 32'h0000_4123, 1'b0}, // R5
    {3'd4, 2'd0, 8'd8,  1'b1, 32'h0000_0096, 32'h0000_0096, 1'b0}, // R5
    {3'd5, 2'd3, 8'd1,  1'b0, 32'h0000_0001, 32'h8000_0000, 1'b1}, // R5
    {3'd6, 2'd0, 8'd1,  1'b1, 32'h0000_0080, 32'h0000_0001, 1'b1}, // R6
    {3'd6, 2'd0, 8'd9,  1'b1, 32'h0000_005A, 32'h0000_005A, 1'b1}, // R6
    {3'd7, 2'd0, 8'd1,  1'b0, 32'h0000_0001, 32'h0000_0000, 1'b1}, // R6
    {3'd7, 2'd1, 8'd18, 1'b1, 32'h0000_0002, 32'h0000_8001, 1'b0}, // R6
    {3'd0, 2'd0, 8'h21, 1'b0, 32'h0000_0040, 32'h0000_0080, 1'b0}, // R7
    {3'd2, 2'd0, 8'd1,  1'b0, 32'hFFFF_FF02, 32'h0000_0001, 1'b0}, // R11
    {3'd6, 2'd2, 8'd1,  1'b0, 32'h8000_0000, 32'h0000_0000, 1'b1}  // R6
  };

  function automatic string req_of(input logic [2:0] o, input logic [7:0] c);
    if (c[7:5] != 3'd0) return "R7";
    case (o)
      3'd0, 3'd1: return "R1/R4";
      3'd2:       return "R2/R4";
      3'd3:       return "R3/R4";
      3'd4, 3'd5: return "R5";
      default:    return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s, input logic [7:0] c,
                       input logic ci, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; op = o; size = s; count = c; carry_in = ci; operand = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", 32'(out_valid), 32'd0);
    check("R10 reset result", result, 32'd0);
    check("R10 reset flags", {29'd0, carry_out, zero_out, sign_out}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] vo; logic [1:0] vs; logic [7:0] vc; logic vci;
      logic [31:0] vd, er; logic ecf; int top;
      {vo, vs, vc, vci, vd, er, ecf} = VEC[i];
      apply(vo, vs, vc, vci, vd);
      check({req_of(vo, vc), " result"}, result, er);
      check({req_of(vo, vc), " carry"}, 32'(carry_out), 32'(ecf));
      check("R10 out_valid", 32'(out_valid), 32'd1);
      if (vo < 3'd4 && vc[4:0] != 5'd0) begin
        top = (vs == 2'd0) ? 7 : (vs == 2'd1) ? 15 : 31;
        check("R9 zero flag", 32'(zero_out), 32'(er == 32'd0));
        check("R9 sign flag", 32'(sign_out), 32'(er[top]));
      end
    end

    @(negedge clk);
    check("R10 out_valid idle", 32'(out_valid), 32'd0);

    // zero_out set by a shift, then a zero-count request must hold it
    apply(3'd0, 2'd0, 8'd8, 1'b0, 32'h0000_0001);
    check("R9 zero flag set", 32'(zero_out), 32'd1);
    apply(3'd2, 2'd0, 8'h20, 1'b1, 32'h1234_5680);
    check("R8 zero count result", result, 32'h0000_0080);
    check("R8 zero count carry", 32'(carry_out), 32'd1);
    check("R8 zero count flags", {30'd0, zero_out, sign_out}, 32'd2);

    // sign_out set by a shift, then a rotate giving zero must leave flags
    apply(3'd0, 2'd0, 8'd1, 1'b0, 32'h0000_0040);
    check("R9 sign flag set", {30'd0, zero_out, sign_out}, 32'd1);
    apply(3'd4, 2'd0, 8'd1, 1'b1, 32'h0000_0000);
    check("R9 rotate result", result, 32'd0);
    check("R9 rotate flags held", {30'd0, zero_out, sign_out}, 32'd1);

    // left shift names agree on a 32-bit operand
    apply(3'd1, 2'd2, 8'd31, 1'b0, 32'h0000_0003);
    check("R1 sal 32 result", result, 32'h8000_0000);
    check("R1 sal 32 carry", 32'(carry_out), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule